// File: doc/BRIEF.md
# Programmable Interval Timer with Coherent Capture

This block is a down-counting interval timer that sits on a simple word-addressed write/read bus. Software programs a timeout value into two half-width period registers. It then starts the counter, and the counter signals each time it reaches zero. The counter may keep running after zero (continuous) or halt after one pass (one-shot). An interrupt line follows a sticky timeout flag, gated by an enable bit.

The full-width counter can be read without tearing. A write to either capture word latches the whole counter into a capture register in a single cycle, and both halves can then be read at leisure.

Two build-time options change the variant. Without run control, the counter runs from reset and cannot be stopped. With a fixed period, writes to the period words only restart the counter from the built-in value.

Top module: `ivTimer`

## Requirements
- R1: The read word map is as follows. Word 0 is status: bit0 is the timeout flag and bit1 is running. Word 1 is control: bit0 is interrupt enable and bit1 is continuous mode. Words 2 and 3 are the period low and high halves, and words 4 and 5 are the capture low and high halves.
- R2: When the period is writeable, a write to word 2 or word 3 updates that half. In the same edge it loads the counter with the new combined value.
- R3: While running, the counter decrements by one per cycle. It holds zero for one cycle and then reloads from the period, so one timeout interval lasts period+1 cycles.
- R4: With run control present, a write to either period word leaves the counter stopped.
- R5: Without run control, the counter runs from reset onward. Period writes do not stop it, and the continuous bit has no effect, so operation is always continuous.
- R6: With a fixed period, a write to either period word discards the data, loads the counter with the built-in period, and leaves the period words reading that value.
- R7: A write to word 4 or word 5, with its data ignored, copies the counter value present before that edge into both capture halves together.
- R8: A capture is taken whether the counter is running or stopped. It changes neither the count nor the run state, and a stopped counter holds its value.
- R9: The timeout flag is set at the edge on which a running counter at zero reloads. The interrupt output is high exactly while the flag and the enable are both 1.
- R10: Any write to word 0 clears the timeout flag. If the flag is set in the same cycle, the set wins.
- R11: Writing control with bit0 at 0 drops the interrupt but leaves the timeout flag set.
- R12: Control bit2 (start) and bit3 (stop) are write-one strobes that read back as 0. When both are written as 1 together, stop wins.
- R13: In one-shot mode the counter reloads at zero and then stops, and the running bit clears.
- R14: After reset, the period holds the built-in value, the counter holds that value, and the capture reads 0. The flag, the enable and the mode are 0. The counter is stopped when run control is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | 3 | Word address for reads and writes |
| wrData | input | HALF_W | Write data |
| rdData | output | HALF_W | Read data for addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume the bus performs at most one write per cycle. They also assume that read addresses have no side effects, so every condition keys on wrEn plus a single address. The bench never overlaps transactions. Each write occupies exactly one clock edge, and reads happen between edges with wrEn low. Expected intervals and captured counts come from the period+1 rule, counted in edges from the start write. The checker's reload property excludes period writes, because that is the only case in which the bus legitimately overrides a zero-count reload.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam logic [2:0] ADDR_STATUS = 3'd0;
  localparam logic [2:0] ADDR_CTRL   = 3'd1;
  localparam logic [2:0] ADDR_PER_LO = 3'd2;
  localparam logic [2:0] ADDR_PER_HI = 3'd3;
  localparam logic [2:0] ADDR_CAP_LO = 3'd4;
  localparam logic [2:0] ADDR_CAP_HI = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic loadFixed;
    logic snapTake;
    logic run;
  } dpCmd_t;
endpackage

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
#(
  parameter bit HAS_RUNCTL = 1'b1,
  parameter bit PERIOD_WR  = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] addr,
  input  logic [3:0] ctlBits,
  input  logic       cntZero,
  output dpCmd_t     cmd,
  output logic       toFlag,
  output logic       runFlag,
  output logic       intEn,
  output logic       contMode,
  output logic       irq
);
  logic isStatus, isCtl, periodWr, zeroHit, startReq, stopReq, runNext;

  assign isStatus = wrEn && (addr == ADDR_STATUS);
  assign isCtl    = wrEn && (addr == ADDR_CTRL);
  assign periodWr = wrEn && ((addr == ADDR_PER_LO) || (addr == ADDR_PER_HI));
  assign zeroHit  = runFlag && cntZero;
  assign startReq = isCtl && ctlBits[2];
  assign stopReq  = isCtl && ctlBits[3];

  generate
    if (HAS_RUNCTL) begin : gRunCtl
      always_comb begin
        if (stopReq)                     runNext = 1'b0;
        else if (startReq)               runNext = 1'b1;
        else if (periodWr)               runNext = 1'b0;
        else if (zeroHit && !contMode)   runNext = 1'b0;
        else                             runNext = runFlag;
      end
    end else begin : gFreeRun
      assign runNext = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runFlag  <= !HAS_RUNCTL;
      toFlag   <= 1'b0;
      intEn    <= 1'b0;
      contMode <= 1'b0;
    end else begin
      runFlag <= runNext;
      if (zeroHit)       toFlag <= 1'b1;
      else if (isStatus) toFlag <= 1'b0;
      if (isCtl) begin
        intEn    <= ctlBits[0];
        contMode <= ctlBits[1];
      end
    end
  end

  always_comb begin
    cmd.wrLo      = PERIOD_WR && wrEn && (addr == ADDR_PER_LO);
    cmd.wrHi      = PERIOD_WR && wrEn && (addr == ADDR_PER_HI);
    cmd.loadFixed = !PERIOD_WR && periodWr;
    cmd.snapTake  = wrEn && ((addr == ADDR_CAP_LO) || (addr == ADDR_CAP_HI));
    cmd.run       = runFlag;
  end

  assign irq = toFlag && intEn;
endmodule

// File: rtl/ivt_datapath.sv
module ivt_datapath
  import ivt_pkg::*;
#(
  parameter int unsigned HALF_W       = 16,
  parameter int unsigned FIXED_PERIOD = 99,
  parameter bit          PERIOD_WR    = 1'b1,
  localparam int unsigned CNT_W       = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [HALF_W-1:0] wrData,
  output logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  periodVal,
  output logic [CNT_W-1:0]  snapVal,
  output logic              cntZero
);
  localparam logic [CNT_W-1:0] FIX_VAL = CNT_W'(FIXED_PERIOD);

  logic [HALF_W-1:0] periodLo, periodHi;
  logic [CNT_W-1:0]  newPeriod;

  generate
    if (PERIOD_WR) begin : gWrPeriod
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          periodLo <= FIX_VAL[HALF_W-1:0];
          periodHi <= FIX_VAL[CNT_W-1:HALF_W];
        end else begin
          if (cmd.wrLo) periodLo <= wrData;
          if (cmd.wrHi) periodHi <= wrData;
        end
      end
    end else begin : gFixPeriod
      assign periodLo = FIX_VAL[HALF_W-1:0];
      assign periodHi = FIX_VAL[CNT_W-1:HALF_W];
    end
  endgenerate

  assign periodVal = {periodHi, periodLo};
  assign newPeriod = {cmd.wrHi ? wrData : periodHi, cmd.wrLo ? wrData : periodLo};
  assign cntZero   = (cntVal == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal  <= FIX_VAL;
      snapVal <= '0;
    end else begin
      if (cmd.wrLo || cmd.wrHi) cntVal <= newPeriod;
      else if (cmd.loadFixed)   cntVal <= FIX_VAL;
      else if (cmd.run)         cntVal <= cntZero ? periodVal : cntVal - CNT_W'(1);
      if (cmd.snapTake) snapVal <= cntVal;
    end
  end
endmodule

// File: rtl/ivTimer.sv
module ivTimer
  import ivt_pkg::*;
#(
  parameter int unsigned HALF_W       = 16,
  parameter int unsigned FIXED_PERIOD = 99,
  parameter bit          HAS_RUNCTL   = 1'b1,
  parameter bit          PERIOD_WR    = 1'b1,
  localparam int unsigned CNT_W       = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] rdData,
  output logic              irq
);
  dpCmd_t           cmd;
  logic [CNT_W-1:0] cntVal, periodVal, snapVal;
  logic             cntZero, toFlag, runFlag, intEn, contMode;

  ivt_ctrl #(.HAS_RUNCTL(HAS_RUNCTL), .PERIOD_WR(PERIOD_WR)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .ctlBits(wrData[3:0]),
    .cntZero(cntZero), .cmd(cmd), .toFlag(toFlag), .runFlag(runFlag),
    .intEn(intEn), .contMode(contMode), .irq(irq)
  );

  ivt_datapath #(.HALF_W(HALF_W), .FIXED_PERIOD(FIXED_PERIOD), .PERIOD_WR(PERIOD_WR)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData), .cntVal(cntVal),
    .periodVal(periodVal), .snapVal(snapVal), .cntZero(cntZero)
  );

  always_comb begin
    case (addr)
      ADDR_STATUS: rdData = HALF_W'({runFlag, toFlag});
      ADDR_CTRL:   rdData = HALF_W'({contMode, intEn});
      ADDR_PER_LO: rdData = periodVal[HALF_W-1:0];
      ADDR_PER_HI: rdData = periodVal[CNT_W-1:HALF_W];
      ADDR_CAP_LO: rdData = snapVal[HALF_W-1:0];
      ADDR_CAP_HI: rdData = snapVal[CNT_W-1:HALF_W];
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/ivt_chk.sv
module ivt_chk #(
  parameter int unsigned HALF_W     = 16,
  parameter bit          HAS_RUNCTL = 1'b1,
  localparam int unsigned CNT_W     = 2 * HALF_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [2:0]       addr,
  input logic             ieBit,
  input logic             irq,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] periodVal,
  input logic [CNT_W-1:0] snapVal,
  input logic             runFlag,
  input logic             toFlag
);
  logic perWr, atZero;
  assign perWr  = wrEn && (addr == 3'd2 || addr == 3'd3);
  assign atZero = runFlag && (cntVal == '0);

  // R7
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (addr == 3'd4 || addr == 3'd5) |=> snapVal == $past(cntVal));
  // R8
  snap_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == 3'd4 && runFlag && cntVal != '0 |=> cntVal == $past(cntVal) - CNT_W'(1));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runFlag && !wrEn |=> $stable(cntVal));
  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    atZero && !perWr |=> cntVal == $past(periodVal));
  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    atZero |=> toFlag);
  // R10
  ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == 3'd0 && !atZero |=> !toFlag);
  // R11
  ie_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == 3'd1 && !ieBit |=> !irq);
  // R4
  period_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    HAS_RUNCTL && perWr |=> !runFlag);
endmodule

bind ivTimer ivt_chk #(.HALF_W(HALF_W), .HAS_RUNCTL(HAS_RUNCTL)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .ieBit(wrData[0]),
  .irq(irq), .cntVal(cntVal), .periodVal(periodVal), .snapVal(snapVal),
  .runFlag(runFlag), .toFlag(toFlag)
);

// File: tb/ivTimer_tb_top.sv
module ivTimer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEnA = 1'b0, wrEnB = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdA, rdB;
  logic        irqA, irqB;
  int          total = 0, bad = 0, cycles = 0;

  always #10 clk = ~clk;

  ivTimer dut_i (.clk(clk), .rstN(rstN), .wrEn(wrEnA), .addr(addr),
                 .wrData(wrData), .rdData(rdA), .irq(irqA));

  ivTimer #(.FIXED_PERIOD(5), .HAS_RUNCTL(1'b0), .PERIOD_WR(1'b0)) fixDut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEnB), .addr(addr),
    .wrData(wrData), .rdData(rdB), .irq(irqB));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input bit sel, input logic [2:0] a, input logic [15:0] d);
    addr = a; wrData = d;
    if (sel) wrEnB = 1'b1; else wrEnA = 1'b1;
    @(negedge clk);
    wrEnA = 1'b0; wrEnB = 1'b0;
  endtask

  task automatic rd(input bit sel, input logic [2:0] a, output logic [15:0] v);
    addr = a; #1;
    v = sel ? rdB : rdA;
  endtask

  task automatic waitIrq(input bit sel, output int n);
    n = 0;
    while (!(sel ? irqB : irqA) && n < 300) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic rd32(input bit sel, input logic [2:0] lo, output logic [31:0] v);
    logic [15:0] l, h;
    rd(sel, lo, l); rd(sel, lo + 3'd1, h);
    v = {h, l};
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=below 150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [31:0] w;
    int n, m;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R14 reset state
    rd(0, 3'd0, v); chk("R14 status", v, 0);
    rd(0, 3'd1, v); chk("R14 control", v, 0);
    rd32(0, 3'd2, w); chk("R14 period", w, 99);
    rd32(0, 3'd4, w); chk("R14 capture", w, 0);
    chk("R14 irq", irqA, 0);
    busWr(0, 3'd4, 16'h1234);
    rd32(0, 3'd4, w); chk("R14 counter loaded and held", w, 99);

    // R3 continuous sweep, R1 map
    for (int p = 0; p < 8; p++) begin
      busWr(0, 3'd2, 16'(p));
      busWr(0, 3'd3, 16'h0);
      busWr(0, 3'd0, 16'h0);
      busWr(0, 3'd1, 16'h7);
      waitIrq(0, n); chk("R3 first interval", n, p + 1);
      rd(0, 3'd1, v); chk("R1 control readback", v, 3);
      busWr(0, 3'd0, 16'h0);
      waitIrq(0, m); chk("R3 repeat interval", m, p);
      busWr(0, 3'd1, 16'h9);
      rd(0, 3'd0, v); chk("R12 stopped after stop", v[1], 0);
    end

    // R13 one-shot
    busWr(0, 3'd2, 16'd3); busWr(0, 3'd3, 16'd0);
    busWr(0, 3'd0, 16'h0); busWr(0, 3'd1, 16'h5);
    waitIrq(0, n); chk("R13 one-shot interval", n, 4);
    rd(0, 3'd0, v); chk("R13 status after one-shot", v, 1);
    busWr(0, 3'd4, 16'hBEEF);
    rd32(0, 3'd4, w); chk("R13 reloaded value kept", w, 3);

    // R11 / R9 / R10 acknowledge paths
    chk("R9 irq high", irqA, 1);
    busWr(0, 3'd1, 16'h0); chk("R11 irq low", irqA, 0);
    rd(0, 3'd0, v); chk("R11 flag kept", v[0], 1);
    busWr(0, 3'd1, 16'h1); chk("R9 irq back", irqA, 1);
    busWr(0, 3'd0, 16'hFFFF); chk("R10 irq cleared", irqA, 0);
    rd(0, 3'd0, v); chk("R10 flag cleared", v[0], 0);

    // R12 start/stop strobes
    busWr(0, 3'd1, 16'hC);
    rd(0, 3'd0, v); chk("R12 stop wins", v[1], 0);
    rd(0, 3'd1, v); chk("R12 strobes read 0", v, 0);
    busWr(0, 3'd1, 16'h4);
    rd(0, 3'd0, v); chk("R12 start runs", v[1], 1);
    rd(0, 3'd1, v); chk("R12 start reads 0", v, 0);
    busWr(0, 3'd1, 16'h8);

    // R7 coherent capture across a half boundary
    busWr(0, 3'd2, 16'd2); busWr(0, 3'd3, 16'd1);
    busWr(0, 3'd1, 16'h6);
    for (int k = 0; k < 5; k++) begin
      busWr(0, (k % 2) ? 3'd5 : 3'd4, 16'hFFFF);
      rd32(0, 3'd4, w); chk("R7 capture", w, 32'h0001_0002 - 32'(k));
    end
    rd(0, 3'd0, v); chk("R8 run kept over capture", v[1], 1);

    // R4 / R2 period write while running
    busWr(0, 3'd2, 16'h0030);
    rd(0, 3'd0, v); chk("R4 period write stops", v[1], 0);
    rd32(0, 3'd2, w); chk("R2 period readback", w, 32'h0001_0030);
    busWr(0, 3'd4, 16'h0);
    rd32(0, 3'd4, w); chk("R2 counter loaded", w, 32'h0001_0030);
    repeat (3) @(negedge clk);
    busWr(0, 3'd5, 16'h0);
    rd32(0, 3'd4, w); chk("R8 stopped hold", w, 32'h0001_0030);

    // R5 / R6 fixed-period, free-running instance
    rd(1, 3'd0, v); chk("R5 runs from reset", v[1], 1);
    rd32(1, 3'd2, w); chk("R6 fixed period", w, 5);
    busWr(1, 3'd2, 16'h0077);
    rd32(1, 3'd2, w); chk("R6 data discarded", w, 5);
    rd(1, 3'd0, v); chk("R5 period write keeps running", v[1], 1);
    busWr(1, 3'd4, 16'h0);
    rd32(1, 3'd4, w); chk("R6 counter reset to fixed", w, 5);
    busWr(1, 3'd1, 16'h1);
    busWr(1, 3'd0, 16'h0);
    if (irqB) busWr(1, 3'd0, 16'h0);
    waitIrq(1, n);
    busWr(1, 3'd0, 16'h0);
    waitIrq(1, m); chk("R5 continuous despite mode 0", m, 5);
    busWr(1, 3'd0, 16'h0);
    waitIrq(1, m); chk("R3 fixed interval", m, 5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule